// File: doc/BRIEF.md
# Paired-Word Configuration Memory Write Controller

This block puts a 16-bit word request port in front of a 32-bit-wide configuration store. The host addresses 80 half-words, and the store holds 40 full words. A read fetches the whole 32-bit word and returns the half that the address selects. A write to an even address is parked in a holding register and does not touch the store. A write to the following odd address joins its data with the parked half and commits the full 32-bit word in one storage cycle.

Writes pass only while a separate key register holds the unlock value 0x77. The top sixteen half-word addresses are a factory region that writes cannot alter. A whole-memory erase request is always refused. Every refused request raises a one-cycle error pulse and leaves both the store and the holding register untouched. The store is modelled as a synchronous RAM without reset, in the way nonvolatile content would behave.

Top module: `cfg_pair_wr_ctrl`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o and err_o are 0, the holding register is zero and the key register is zero, so writes are locked.
- R2: An accepted read (op 2'b00) of an address below 80 sets rsp_valid_o in the cycle after acceptance. rsp_rdata_o carries bits [15:0] of word addr>>1 for an even address and bits [31:16] for an odd address.
- R3: An accepted even-address write (op 2'b01, addr[0]=0) loads the holding register and leaves the store unchanged.
- R4: An accepted odd-address write stores {wdata, holding} (odd data high, even data low) into word addr>>1. req_ready_o is 0 for the one cycle after acceptance and 1 again after that.
- R5: An odd write commits whatever the holding register contains: zero after reset, otherwise the data of the last accepted even write. A commit does not clear it.
- R6: Op 2'b10 loads req_wdata_i[7:0] into the key register, with no response and no error. Writes are accepted only while the key equals 0x77.
- R7: Writes to addresses 0x40 through 0x4F are refused.
- R8: Erase (op 2'b11) is always refused and leaves the store unchanged.
- R9: A refused request sets err_o for exactly the cycle after acceptance and changes neither the store nor the holding register.
- R10: A read or write at an address of 80 or above is refused and gives no rsp_valid_o.
- R11: rsp_valid_o and err_o are never both set, and neither is set unless a request was accepted in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted |
| req_op_i | input | 2 | 00 read, 01 write, 10 load key, 11 erase |
| req_addr_i | input | 7 | Half-word address |
| req_wdata_i | input | 16 | Write data, or key in bits [7:0] |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 16 | Read data, zero when not valid |
| err_o | output | 1 | Request refused pulse |

## Verification
Read data and err_o both arrive in the cycle after the handshake edge. The bench therefore drives each request at a falling edge, lets it be accepted at the next rising edge, and samples the outputs at the falling edge after that. A committing odd write drops req_ready_o in that same sampled cycle, so a directed check looks at ready at that point and again one cycle later. Data that a commit writes becomes visible to a read accepted two edges after the commit's handshake, and the request task waits for ready before it drives the next request, which places every read-back after the store has been updated.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_KEY   = 2'b10,
    OP_ERASE = 2'b11
  } op_e;
endpackage

// File: rtl/cfgmem_ram.sv
module cfgmem_ram #(
  parameter int DEPTH = 40,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i
);
  logic [W-1:0] mem_q [DEPTH];

  // contents are retained, not reset
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/cfgmem_lock.sv
module cfgmem_lock #(
  parameter int          KW  = 8,
  parameter logic [KW-1:0] KEY = 8'h77
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [KW-1:0] key_i,
  output logic          unlocked_o
);
  logic [KW-1:0] key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    key_q <= '0;
    else if (set_i) key_q <= key_i;
  end

  assign unlocked_o = (key_q == KEY);
endmodule

// File: rtl/cfgmem_decode.sv
module cfgmem_decode
  import cfgmem_pkg::*;
#(
  parameter int WORDS      = 80,
  parameter int FACTORY_LO = 64,
  parameter int FACTORY_HI = 79,
  localparam int AW        = $clog2(WORDS)
) (
  input  op_e           op_i,
  input  logic [AW-1:0] addr_i,
  input  logic          unlocked_i,
  output logic          read_ok_o,
  output logic          wr_even_ok_o,
  output logic          wr_odd_ok_o,
  output logic          key_set_o,
  output logic          reject_o
);
  localparam logic [AW-1:0] LIM = AW'(WORDS);
  localparam logic [AW-1:0] FLO = AW'(FACTORY_LO);
  localparam logic [AW-1:0] FHI = AW'(FACTORY_HI);

  logic in_range, factory, wr_ok;

  always_comb begin
    in_range     = addr_i < LIM;
    factory      = (addr_i >= FLO) && (addr_i <= FHI);
    wr_ok        = (op_i == OP_WRITE) && in_range && !factory && unlocked_i;
    read_ok_o    = (op_i == OP_READ) && in_range;
    wr_even_ok_o = wr_ok && !addr_i[0];
    wr_odd_ok_o  = wr_ok && addr_i[0];
    key_set_o    = (op_i == OP_KEY);
    reject_o     = (op_i == OP_ERASE)
                 || ((op_i == OP_READ) && !in_range)
                 || ((op_i == OP_WRITE) && !wr_ok);
  end
endmodule

// File: rtl/cfg_pair_wr_ctrl.sv
module cfg_pair_wr_ctrl
  import cfgmem_pkg::*;
#(
  parameter int            WORDS      = 80,
  parameter int            DW         = 16,
  parameter int            FACTORY_LO = 64,
  parameter int            FACTORY_HI = 79,
  parameter int            KW         = 8,
  parameter logic [KW-1:0] KEY        = 8'h77,
  localparam int           AW         = $clog2(WORDS),
  localparam int           DEPTH      = WORDS / 2,
  localparam int           RAW        = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [1:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          err_o
);
  logic            fire, unlocked;
  logic            read_ok, wr_even_ok, wr_odd_ok, key_set, reject;
  logic [DW-1:0]   hold_q;
  logic            commit_q;
  logic [RAW-1:0]  cwaddr_q;
  logic [2*DW-1:0] cwdata_q;
  logic            rsp_valid_q, half_q, err_q;
  logic [2*DW-1:0] ram_q;
  op_e             op;

  assign op          = op_e'(req_op_i);
  assign req_ready_o = !commit_q;  // stall while the commit owns the RAM
  assign fire        = req_valid_i && req_ready_o;

  cfgmem_decode #(
    .WORDS(WORDS), .FACTORY_LO(FACTORY_LO), .FACTORY_HI(FACTORY_HI)
  ) u_dec (
    .op_i(op), .addr_i(req_addr_i), .unlocked_i(unlocked),
    .read_ok_o(read_ok), .wr_even_ok_o(wr_even_ok), .wr_odd_ok_o(wr_odd_ok),
    .key_set_o(key_set), .reject_o(reject)
  );

  cfgmem_lock #(.KW(KW), .KEY(KEY)) u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(fire && key_set), .key_i(req_wdata_i[KW-1:0]),
    .unlocked_o(unlocked)
  );

  cfgmem_ram #(.DEPTH(DEPTH), .W(2*DW)) u_ram (
    .clk_i(clk_i),
    .re_i(fire && read_ok), .raddr_i(req_addr_i[AW-1:1]), .rdata_o(ram_q),
    .we_i(commit_q), .waddr_i(cwaddr_q), .wdata_i(cwdata_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      commit_q    <= 1'b0;
      cwaddr_q    <= '0;
      cwdata_q    <= '0;
      rsp_valid_q <= 1'b0;
      half_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      commit_q    <= fire && wr_odd_ok;
      rsp_valid_q <= fire && read_ok;
      err_q       <= fire && reject;
      if (fire && wr_even_ok) hold_q <= req_wdata_i;
      if (fire && wr_odd_ok) begin
        cwaddr_q <= req_addr_i[AW-1:1];
        cwdata_q <= {req_wdata_i, hold_q};
      end
      if (fire && read_ok) half_q <= req_addr_i[0];
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = !rsp_valid_q ? '0 : (half_q ? ram_q[2*DW-1:DW] : ram_q[DW-1:0]);
  assign err_o       = err_q;
endmodule

// File: rtl/cfgmem_chk.sv
module cfgmem_chk #(
  parameter int  WORDS      = 80,
  parameter int  FACTORY_LO = 64,
  localparam int AW         = $clog2(WORDS),
  localparam int RAW        = $clog2(WORDS / 2)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_valid_i,
  input logic           req_ready_o,
  input logic [1:0]     req_op_i,
  input logic [AW-1:0]  req_addr_i,
  input logic           rsp_valid_o,
  input logic           err_o,
  input logic           commit_i,
  input logic [RAW-1:0] cwaddr_i,
  input logic           unlocked_i
);
  localparam logic [RAW-1:0] FWORD = RAW'(FACTORY_LO / 2);

  logic fire;
  assign fire = req_valid_i && req_ready_o;

  a_r4_commit_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> !req_ready_o);

  a_r4_commit_from_odd_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> $past(fire && req_op_i == 2'b01 && req_addr_i[0]));

  a_r6_commit_needs_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> $past(unlocked_i));

  a_r7_no_factory_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> cwaddr_i < FWORD);

  a_r11_rsp_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(fire && req_op_i == 2'b00));

  a_r11_err_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(fire));

  a_r11_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_valid_o && err_o));
endmodule

bind cfg_pair_wr_ctrl cfgmem_chk #(.WORDS(WORDS), .FACTORY_LO(FACTORY_LO)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .req_op_i(req_op_i), .req_addr_i(req_addr_i),
  .rsp_valid_o(rsp_valid_o), .err_o(err_o), .commit_i(commit_q),
  .cwaddr_i(cwaddr_q), .unlocked_i(unlocked)
);

// File: tb/sim_cfg_pair_wr_ctrl.sv
module sim_cfg_pair_wr_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        ready;
  logic [1:0]  op = 2'b00;
  logic [6:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        rsp_valid, err;
  logic [15:0] rdata;
  int          n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = !clk;

  cfg_pair_wr_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_op_i(op), .req_addr_i(addr), .req_wdata_i(wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rdata), .err_o(err)
  );

  // {op, addr, wdata, exp_err, exp_rsp, exp_rdata, req}
  localparam int NV = 27;
  localparam logic [46:0] VEC [NV] = '{
    {2'd2, 7'h00, 16'h0077, 1'b0, 1'b0, 16'h0000, 4'd6},  // R6 unlock
    {2'd1, 7'h00, 16'h1111, 1'b0, 1'b0, 16'h0000, 4'd3},  // R3
    {2'd1, 7'h01, 16'h2222, 1'b0, 1'b0, 16'h0000, 4'd4},  // R4
    {2'd0, 7'h00, 16'h0000, 1'b0, 1'b1, 16'h1111, 4'd2},  // R2 low half
    {2'd0, 7'h01, 16'h0000, 1'b0, 1'b1, 16'h2222, 4'd2},  // R2 high half
    {2'd1, 7'h00, 16'h3333, 1'b0, 1'b0, 16'h0000, 4'd3},  // R3
    {2'd0, 7'h00, 16'h0000, 1'b0, 1'b1, 16'h1111, 4'd3},  // R3 store untouched
    {2'd1, 7'h01, 16'h4444, 1'b0, 1'b0, 16'h0000, 4'd4},  // R4
    {2'd0, 7'h00, 16'h0000, 1'b0, 1'b1, 16'h3333, 4'd4},  // R4
    {2'd0, 7'h01, 16'h0000, 1'b0, 1'b1, 16'h4444, 4'd4},  // R4
    {2'd1, 7'h4E, 16'h5555, 1'b1, 1'b0, 16'h0000, 4'd7},  // R7
    {2'd1, 7'h4F, 16'h6666, 1'b1, 1'b0, 16'h0000, 4'd7},  // R7
    {2'd1, 7'h3E, 16'h1234, 1'b0, 1'b0, 16'h0000, 4'd7},  // R7 edge below
    {2'd1, 7'h3F, 16'h5678, 1'b0, 1'b0, 16'h0000, 4'd7},  // R7
    {2'd0, 7'h3E, 16'h0000, 1'b0, 1'b1, 16'h1234, 4'd7},  // R7
    {2'd0, 7'h3F, 16'h0000, 1'b0, 1'b1, 16'h5678, 4'd7},  // R7
    {2'd3, 7'h00, 16'h0000, 1'b1, 1'b0, 16'h0000, 4'd8},  // R8
    {2'd0, 7'h00, 16'h0000, 1'b0, 1'b1, 16'h3333, 4'd8},  // R8 unchanged
    {2'd2, 7'h00, 16'h0076, 1'b0, 1'b0, 16'h0000, 4'd6},  // R6 wrong key
    {2'd1, 7'h02, 16'h9999, 1'b1, 1'b0, 16'h0000, 4'd6},  // R6
    {2'd1, 7'h03, 16'h8888, 1'b1, 1'b0, 16'h0000, 4'd9},  // R9
    {2'd2, 7'h00, 16'h0077, 1'b0, 1'b0, 16'h0000, 4'd6},  // R6
    {2'd1, 7'h03, 16'h7777, 1'b0, 1'b0, 16'h0000, 4'd5},  // R5
    {2'd0, 7'h02, 16'h0000, 1'b0, 1'b1, 16'h1234, 4'd9},  // R9 hold kept from 0x3E
    {2'd0, 7'h03, 16'h0000, 1'b0, 1'b1, 16'h7777, 4'd5},  // R5
    {2'd0, 7'h50, 16'h0000, 1'b1, 1'b0, 16'h0000, 4'd10}, // R10
    {2'd1, 7'h51, 16'hABCD, 1'b1, 1'b0, 16'h0000, 4'd10}  // R10
  };

  task automatic check(input bit ok, input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at falling edge, accepted at rising edge, sampled at the next falling edge
  task automatic issue(input logic [1:0] o, input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    while (!ready) @(negedge clk);
    valid = 1'b1; op = o; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ready === 1'b1 && rsp_valid === 1'b0 && err === 1'b0, 1,
          {29'd0, ready, rsp_valid, err}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 locked after reset: write refused
    issue(2'd1, 7'h00, 16'hDEAD);
    check(err === 1'b1, 1, {31'd0, err}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      logic [46:0] v;
      v = VEC[i];
      issue(v[46:45], v[44:38], v[37:22]);
      check(err === v[21] && rsp_valid === v[20] && (!v[20] || rdata === v[19:4]),
            int'(v[3:0]), {14'd0, err, rsp_valid, rdata}, {14'd0, v[21:20], v[19:4]});
    end

    // R4 ready low for exactly one cycle after an odd commit
    issue(2'd1, 7'h06, 16'h0A0A);
    @(negedge clk); valid = 1'b1; op = 2'd1; addr = 7'h07; wdata = 16'h0B0B;
    @(negedge clk); valid = 1'b0;
    check(ready === 1'b0, 4, {31'd0, ready}, 32'd0);
    @(negedge clk);
    check(ready === 1'b1, 4, {31'd0, ready}, 32'd1);
    issue(2'd0, 7'h07, 16'h0);
    check(rsp_valid === 1'b1 && rdata === 16'h0B0B, 4, {15'd0, rsp_valid, rdata}, 32'h10B0B);

    // R11 idle cycles give no response and no error
    repeat (2) @(negedge clk);
    check(rsp_valid === 1'b0 && err === 1'b0, 11, {30'd0, rsp_valid, err}, 32'd0);

    // R5 holding register is zero after reset
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    issue(2'd2, 7'h00, 16'h0077);
    issue(2'd1, 7'h05, 16'hCAFE);
    issue(2'd0, 7'h04, 16'h0);
    check(rsp_valid === 1'b1 && rdata === 16'h0000, 5, {15'd0, rsp_valid, rdata}, 32'h10000);
    issue(2'd0, 7'h05, 16'h0);
    check(rsp_valid === 1'b1 && rdata === 16'hCAFE, 5, {15'd0, rsp_valid, rdata}, 32'h1CAFE);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog actual=%0d expected=<20000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule